// File: doc/BRIEF.md
# Receive Buffer Descriptor Alternation Controller

This block holds the 16-bit control word kept alongside one receive data buffer of a command-response serial bus remote terminal. The protocol engine tells it when a message is in progress and when one completes, together with flags for error, illegal command, broadcast and receive direction. From these the block picks buffer A or buffer B for the next message, keeps the pointer, accessed, broadcast and acknowledge status bits, and raises a one-cycle interrupt request when the host has enabled it.

The host reads and writes the word through a simple single-cycle port. The host can pause the alternation between buffers with a stop request, which lets it drain a buffer without a collision. The block drops the acknowledge bit to show that the pause is in effect. A make-busy bit forces a Busy reply, blocks storage of received data and freezes the pointer.

Top module: `mode_desc_pingpong`

## Requirements
- R1: The word read on `host_rdata` carries interrupt-on-access enable at bit 14, broadcast interrupt enable at bit 13, make-busy at bit 12, accessed at bit 11, pointer at bit 10, broadcast-received at bit 9, alternation acknowledge at bit 8, stop request at bit 3 and alternation enable at bit 2. All other bits read 0. A host write changes only bits 14, 13, 12, 3 and 2, and the change is visible from the next cycle. A write in the same cycle as a completion strobe is evaluated against the word's old value.
- R2: `buf_sel` equals the pointer bit, where 0 selects buffer A and 1 selects buffer B. When alternation is enabled and acknowledged, the pointer inverts in the cycle after a completion strobe that has no error, no illegal flag and no make-busy.
- R3: The pointer holds after a completion strobe that carries the error or illegal flag, or that occurs while make-busy is set.
- R4: While make-busy is set, `busy_out` is 1 and `store_en` is 0. Otherwise `busy_out` is 0 and `store_en` is 1.
- R5: On any cycle where `msg_active` is low, the acknowledge bit is updated to (enable AND NOT stop). While `msg_active` is high it holds, so a stop request raised during a message takes effect only after that message.
- R6: While alternation is disabled, or enabled but not acknowledged, the pointer does not change, and every message uses the buffer it selects.
- R7: A valid completion strobe sets the accessed bit in the next cycle. A host read clears it in the next cycle. If a read and a valid strobe occur in the same cycle, the bit is set.
- R8: The broadcast-received bit is set after a valid completion strobe that carries the broadcast flag with no error or illegal flag. Only a reset clears it.
- R9: `irq` pulses for one cycle, one cycle after an error-free, legal, valid completion strobe, when either of two conditions holds. The first is that bit 14 and `irq_access_en` are both high. The second is that bit 13, `irq_bcast_en`, the broadcast flag and the receive flag are all high.
- R10: While `bcast_off` is high, a completion strobe carrying the broadcast flag is not valid, and it leaves the status bits, the pointer and `irq` unchanged.
- R11: `rst_n` low clears the whole word and `irq`. `soft_rst` clears the accessed, pointer, broadcast-received and acknowledge bits and `irq` in the next cycle, so that the next message uses buffer A. Under `soft_rst`, host-writable bits are kept or are written as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| soft_rst | input | 1 | Synchronous software reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Current control word |
| msg_active | input | 1 | A message is in progress |
| msg_done | input | 1 | Message completion strobe |
| msg_error | input | 1 | Completed message ended in error |
| msg_illegal | input | 1 | Completed command was illegal |
| msg_bcast | input | 1 | Completed message was broadcast |
| msg_rx | input | 1 | Completed message was receive direction |
| bcast_off | input | 1 | Broadcast disabled by configuration |
| irq_access_en | input | 1 | Global enable for access interrupt |
| irq_bcast_en | input | 1 | Global enable for broadcast interrupt |
| buf_sel | output | 1 | Buffer for next message: 0 = A, 1 = B |
| busy_out | output | 1 | Answer with Busy status |
| store_en | output | 1 | Received data words may be stored |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The embedded properties check several rules on every cycle: the pointer holds after faulty or busy completions, the acknowledge bit is frozen during a message, an interrupt only follows a completion strobe, the accessed bit is set after a valid strobe, and the pointer clears after a software reset. The bench's scenarios are needed for the effects that span several cycles. These are the stop/acknowledge round trip across a message boundary, the pointer sequence over runs of clean and faulty messages, broadcast suppression, and read-versus-strobe collisions. A cycle-accurate behavioural model covers those scenarios and also a long random run, comparing every output on every clock.

// File: rtl/mode_desc_pingpong.sv
module mode_desc_pingpong (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        msg_active,
  input  logic        msg_done,
  input  logic        msg_error,
  input  logic        msg_illegal,
  input  logic        msg_bcast,
  input  logic        msg_rx,
  input  logic        bcast_off,
  input  logic        irq_access_en,
  input  logic        irq_bcast_en,
  output logic        buf_sel,
  output logic        busy_out,
  output logic        store_en,
  output logic        irq
);

  logic iwa_en, bcst_int_en, mk_busy, stop_req, alt_en;
  logic accessed, ptr, bcst_seen, alt_ack;

  wire done_valid = msg_done && !(msg_bcast && bcast_off);
  wire done_clean = done_valid && !msg_error && !msg_illegal;
  wire do_flip    = done_clean && !mk_busy && alt_en && alt_ack;
  wire irq_cause  = done_clean &&
                    ((iwa_en && irq_access_en) ||
                     (bcst_int_en && irq_bcast_en && msg_bcast && msg_rx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iwa_en      <= 1'b0;
      bcst_int_en <= 1'b0;
      mk_busy     <= 1'b0;
      stop_req    <= 1'b0;
      alt_en      <= 1'b0;
    end else if (host_wr) begin
      iwa_en      <= host_wdata[14];
      bcst_int_en <= host_wdata[13];
      mk_busy     <= host_wdata[12];
      stop_req    <= host_wdata[3];
      alt_en      <= host_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accessed  <= 1'b0;
      ptr       <= 1'b0;
      bcst_seen <= 1'b0;
      alt_ack   <= 1'b0;
      irq       <= 1'b0;
    end else if (soft_rst) begin
      accessed  <= 1'b0;
      ptr       <= 1'b0;
      bcst_seen <= 1'b0;
      alt_ack   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= irq_cause;
      if (do_flip)
        ptr <= !ptr;
      if (done_valid)
        accessed <= 1'b1;
      else if (host_rd)
        accessed <= 1'b0;
      if (done_clean && msg_bcast)
        bcst_seen <= 1'b1;
      if (!msg_active)
        alt_ack <= alt_en && !stop_req;
    end
  end

  assign host_rdata = {1'b0, iwa_en, bcst_int_en, mk_busy, accessed, ptr,
                       bcst_seen, alt_ack, 4'b0000, stop_req, alt_en, 2'b00};
  assign buf_sel    = ptr;
  assign busy_out   = mk_busy;
  assign store_en   = !mk_busy;

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && (msg_error || msg_illegal || mk_busy) && !soft_rst)
      |=> (buf_sel == $past(buf_sel)));

  p_ack_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_active && !soft_rst) |=> $stable(alt_ack));

  p_irq_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(msg_done));

  p_accessed_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !soft_rst) |=> host_rdata[11]);

  p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!buf_sel && !irq && !host_rdata[11]));

  p_paused_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(alt_en && alt_ack) && !soft_rst) |=> $stable(buf_sel));

endmodule

// File: tb/sim_mode_desc_pingpong.sv
module sim_mode_desc_pingpong;
  logic clk = 0, rst_n = 0, soft_rst = 0, host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic msg_active = 0, msg_done = 0, msg_error = 0, msg_illegal = 0;
  logic msg_bcast = 0, msg_rx = 0, bcast_off = 0;
  logic irq_access_en = 0, irq_bcast_en = 0;
  logic buf_sel, busy_out, store_en, irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mode_desc_pingpong u0 (.*);

  // reference model state
  bit m_iwa, m_ibr, m_busy, m_stop, m_en, m_acc, m_ptr, m_bcr, m_ack, m_irq;

  always @(posedge clk) begin
    bit vd, ok, o_en, o_stop, o_busy, o_ack;
    if (!rst_n) begin
      {m_iwa, m_ibr, m_busy, m_stop, m_en, m_acc, m_ptr, m_bcr, m_ack, m_irq} = '0;
    end else begin
      vd = msg_done && !(msg_bcast && bcast_off);
      ok = vd && !msg_error && !msg_illegal;
      o_en = m_en; o_stop = m_stop; o_busy = m_busy; o_ack = m_ack;
      if (soft_rst) begin
        m_acc = 0; m_ptr = 0; m_bcr = 0; m_ack = 0; m_irq = 0;
      end else begin
        m_irq = ok && ((m_iwa && irq_access_en) ||
                       (m_ibr && irq_bcast_en && msg_bcast && msg_rx));
        if (ok && !o_busy && o_en && o_ack) m_ptr = !m_ptr;
        if (vd) m_acc = 1; else if (host_rd) m_acc = 0;
        if (ok && msg_bcast) m_bcr = 1;
        if (!msg_active) m_ack = o_en && !o_stop;
      end
      if (host_wr) begin
        m_iwa = host_wdata[14]; m_ibr = host_wdata[13]; m_busy = host_wdata[12];
        m_stop = host_wdata[3]; m_en = host_wdata[2];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every field each clock, away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1 host bits", {host_rdata[15:12], host_rdata[7:0] & 8'hF3},
        {1'b0, m_iwa, m_ibr, m_busy, 8'h00});
    chk("R1 host bits", host_rdata[3:2], {m_stop, m_en});
    chk("R2 pointer", {buf_sel, host_rdata[10]}, {m_ptr, m_ptr});
    chk("R4 busy", {busy_out, store_en}, {m_busy, !m_busy});
    chk("R5 ack", host_rdata[8], m_ack);
    chk("R7 accessed", host_rdata[11], m_acc);
    chk("R8 bcast seen", host_rdata[9], m_bcr);
    chk("R9 irq", irq, m_irq);
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    host_wr = 1; host_wdata = d; cyc(); host_wr = 0;
  endtask

  task automatic msg(input bit err, input bit ill, input bit bc, input bit rx);
    msg_active = 1; cyc(2);
    msg_done = 1; msg_error = err; msg_illegal = ill; msg_bcast = bc; msg_rx = rx;
    cyc();
    msg_done = 0; msg_error = 0; msg_illegal = 0; msg_bcast = 0; msg_rx = 0;
    msg_active = 0; cyc(2);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc();
    chk("R11 reset word", host_rdata, 0);
    irq_access_en = 1; irq_bcast_en = 1;
    wr(16'h6004); cyc(2);
    chk("R5 ack up", host_rdata[8], 1);
    msg(0,0,0,0);
    chk("R2 flip to B", buf_sel, 1);
    msg(1,0,0,0); chk("R3 error holds", buf_sel, 1);
    msg(0,1,0,0); chk("R3 illegal holds", buf_sel, 1);
    wr(16'h7004); chk("R4 busy on", store_en, 0);
    msg(0,0,0,0); chk("R3 busy holds", buf_sel, 1);
    wr(16'h6004);
    // stop request raised mid-message
    msg_active = 1; cyc(); wr(16'h600C); cyc();
    chk("R5 ack frozen in message", host_rdata[8], 1);
    msg_done = 1; cyc(); msg_done = 0; msg_active = 0; cyc(2);
    chk("R5 ack dropped after message", host_rdata[8], 0);
    chk("R2 last flip before pause", buf_sel, 0);
    msg(0,0,0,0); chk("R6 paused holds", buf_sel, 0);
    wr(16'h6004); cyc(2);
    msg(0,0,1,1); chk("R8 bcast bit", host_rdata[9], 1);
    host_rd = 1; cyc(); host_rd = 0;
    chk("R7 read clears", host_rdata[11], 0);
    soft_rst = 1; cyc(); soft_rst = 0;
    chk("R11 soft reset", {host_rdata[11:8], buf_sel}, 0);
    chk("R11 host bits kept", host_rdata[14:12], 3'b110);
    bcast_off = 1; cyc(2);
    msg(0,0,1,1); chk("R10 ignored", {host_rdata[11:9], buf_sel}, 0);
    bcast_off = 0;
    for (int i = 0; i < 4000; i++) begin
      host_wr = ($urandom % 8) == 0;
      host_wdata = 16'($urandom);
      host_rd = ($urandom % 5) == 0;
      soft_rst = ($urandom % 97) == 0;
      msg_active = ($urandom % 3) != 0;
      msg_done = ($urandom % 4) == 0;
      msg_error = ($urandom % 6) == 0;
      msg_illegal = ($urandom % 8) == 0;
      msg_bcast = ($urandom % 3) == 0;
      msg_rx = $urandom % 2;
      bcast_off = ($urandom % 5) == 0;
      irq_access_en = $urandom % 2;
      irq_bcast_en = $urandom % 2;
      cyc();
    end
    {host_wr, host_rd, soft_rst, msg_active, msg_done} = '0;
    cyc(2);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule